// File: doc/BRIEF.md
# Barrel Shifter Second-Operand Generator

This combinational unit produces the second ALU operand of a 32-bit RISC datapath, together with the carry flag that a logical or move operation should write. It takes a 12-bit operand field from the instruction. The field either describes a shift of a source register or describes an 8-bit constant rotated into place. The register values are read outside the unit and arrive as inputs. When the source index names the program counter, the unit uses the instruction address advanced by 8 in place of the register value.

Shifts come in four kinds: left logical, right logical, right arithmetic and rotate right. Each kind takes its amount either from a 5-bit constant in the field or from the low byte of a second register. Every zero-amount and out-of-range corner follows a fixed carry rule. A separate enable tells the flag logic whether the carry result may be written. It depends on the set-flags bit and on whether the ALU operation computes its own carry.

Top module: `shifter_operand`

## Requirements
- R1: When field bits [3:0] equal 15, the shifted source is `pc` plus 8 instead of `rm_val`.
- R2: In shift form (`imm_form`=0), a field whose bits [11:4] are all zero returns the source unchanged, with `carry_out` equal to `carry_in`.
- R3: Kind 0 (bits [6:4]=0, left shift by bits [11:7]) with an amount n of 1 to 31 returns the source shifted left by n, with carry equal to source bit 32-n.
- R4: Kinds 2 and 4 (right logical and right arithmetic by constant) treat a constant of 0 as 32. Logical returns 0 and arithmetic returns 32 copies of the sign bit, and in both cases the carry is source bit 31.
- R5: Odd kinds take the amount from `rs_val[7:0]` only, and bits above 7 have no effect. An amount of 0 returns the source unchanged, with `carry_out` equal to `carry_in`.
- R6: Kinds 1 and 3 (left and right logical by register) with an amount of 32 return 0, with carry equal to source bit 0 for the left shift and source bit 31 for the right shift. With amounts above 32 they return 0 with carry 0.
- R7: Kind 5 (right arithmetic by register) with an amount of 32 or more returns every bit equal to the sign bit, and the carry is the sign bit.
- R8: Kind 6 (rotate right by constant) with an amount of 0 shifts `carry_in` into bit 31 and the source bits [31:1] into bits [30:0], with carry equal to source bit 0. Amounts of 1 to 31 rotate, with carry equal to source bit n-1.
- R9: Kind 7 (rotate right by register) rotates by the amount mod 32. A nonzero amount that is a multiple of 32 returns the source unchanged, with carry equal to source bit 31.
- R10: Right logical, right arithmetic and rotate by an amount n of 1 to 31 give the carry as source bit n-1.
- R11: In immediate form (`imm_form`=1), the operand is bits [7:0] zero-extended and rotated right by twice bits [11:8]. The carry is result bit 31 when bits [11:8] are nonzero and `carry_in` when they are zero.
- R12: `carry_we` is 1 only when `s_bit` is 1 and `alu_op` is not one of 2, 3, 4, 5, 6, 7, 10 or 11, the codes of the operations that compute their own carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_form | input | 1 | 1 selects the rotated 8-bit constant, 0 selects the shifted register |
| opfield | input | 12 | Operand field of the instruction |
| rm_val | input | 32 | Value of the register named by bits [3:0] |
| rs_val | input | 32 | Value of the register named by bits [11:8] |
| pc | input | 32 | Address of the current instruction |
| carry_in | input | 1 | Current carry flag |
| s_bit | input | 1 | Set-flags bit of the instruction |
| alu_op | input | 4 | ALU operation code |
| operand | output | 32 | Shifted or rotated second operand |
| carry_out | output | 1 | Carry produced by the shift or rotation |
| carry_we | output | 1 | Permission to write `carry_out` to the flag |

## Verification
Every shift kind is swept over all 32 constant amounts. Register amounts run from 0 to 40 and also take 63, 64, 96, 128 and 255. These amounts are combined with source words of distinct bit shapes and both carry inputs. The sweep separates each amount boundary (0, 1, 31, 32, 33 and multiples of 32) and shows whether a carry was taken from the right bit or passed through. High garbage in the amount register shows that only the low byte counts. Sources named by index 15 show the PC-ahead read. All rotate fields are applied to several constants, and every opcode is applied with both set-flags values, to check the write enable.

// File: rtl/shifter_operand.sv
module shifter_operand #(
  parameter int XLEN     = 32,
  parameter int PC_AHEAD = 8
) (
  input  logic            imm_form,
  input  logic [11:0]     opfield,
  input  logic [XLEN-1:0] rm_val,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] pc,
  input  logic            carry_in,
  input  logic            s_bit,
  input  logic [3:0]      alu_op,
  output logic [XLEN-1:0] operand,
  output logic            carry_out,
  output logic            carry_we
);
  localparam int SW = $clog2(XLEN);
  localparam logic [3:0] PC_IDX = 4'd15;

  logic [XLEN-1:0]   src;
  logic [2:0]        kind;
  logic              by_reg;
  logic [7:0]        amt;
  logic [SW-1:0]     k, km1, nk;
  logic              in_range, exact;
  logic [XLEN-1:0]   shl, shr, sar, rot, rimm;
  logic [2*XLEN-1:0] dbl, idbl;
  logic              last_l, last_r, msb;

  assign src      = (opfield[3:0] == PC_IDX) ? pc + XLEN'(PC_AHEAD) : rm_val;
  assign kind     = opfield[6:4];
  assign by_reg   = kind[0];
  assign amt      = by_reg ? rs_val[7:0] : {3'b000, opfield[11:7]};
  assign k        = amt[SW-1:0];
  assign km1      = k - SW'(1);
  assign nk       = ~k + SW'(1);
  assign in_range = amt < 8'(XLEN);
  assign exact    = amt == 8'(XLEN);
  assign msb      = src[XLEN-1];

  assign dbl    = {src, src};
  assign shl    = src << k;
  assign shr    = src >> k;
  assign sar    = $unsigned($signed(src) >>> k);
  assign rot    = dbl[XLEN-1:0] == src ? XLEN'(dbl >> k) : src;
  assign last_l = src[nk];
  assign last_r = src[km1];

  assign idbl = {2{XLEN'(opfield[7:0])}};
  assign rimm = XLEN'(idbl >> {opfield[11:8], 1'b0});

  always_comb begin
    operand   = src;
    carry_out = carry_in;
    if (imm_form) begin
      operand   = rimm;
      carry_out = (opfield[11:8] != 4'd0) ? rimm[XLEN-1] : carry_in;
    end else if (!(by_reg && amt == 8'd0)) begin
      case (kind)
        3'd0: if (k != '0) begin operand = shl; carry_out = last_l; end
        3'd1: begin
          if (in_range)   begin operand = shl; carry_out = last_l; end
          else if (exact) begin operand = '0;  carry_out = src[0]; end
          else            begin operand = '0;  carry_out = 1'b0;   end
        end
        3'd2: begin
          if (k == '0) begin operand = '0;  carry_out = msb;    end
          else         begin operand = shr; carry_out = last_r; end
        end
        3'd3: begin
          if (in_range)   begin operand = shr; carry_out = last_r; end
          else if (exact) begin operand = '0;  carry_out = msb;    end
          else            begin operand = '0;  carry_out = 1'b0;   end
        end
        3'd4: begin
          if (k == '0) begin operand = {XLEN{msb}}; carry_out = msb;    end
          else         begin operand = sar;         carry_out = last_r; end
        end
        3'd5: begin
          if (in_range) begin operand = sar;         carry_out = last_r; end
          else          begin operand = {XLEN{msb}}; carry_out = msb;    end
        end
        3'd6: begin
          if (k == '0) begin operand = {carry_in, src[XLEN-1:1]}; carry_out = src[0]; end
          else         begin operand = rot;                       carry_out = last_r; end
        end
        default: begin
          if (k == '0) begin operand = src; carry_out = msb;    end
          else         begin operand = rot; carry_out = last_r; end
        end
      endcase
    end

    if (!imm_form && opfield[11:4] == 8'd0)
      a_r2_passthru: assert (operand == src && carry_out == carry_in);
    if (!imm_form && by_reg && rs_val[7:0] == 8'd0)
      a_r5_zero_amount: assert (operand == src && carry_out == carry_in);
    if (!imm_form && (kind == 3'd1 || kind == 3'd3) && rs_val[7:0] > 8'(XLEN))
      a_r6_over_range: assert (operand == '0 && !carry_out);
    if (!imm_form && kind == 3'd5 && rs_val[7:0] >= 8'(XLEN))
      a_r7_sign_fill: assert (($countones(operand) == 0 || $countones(operand) == XLEN)
                              && carry_out == operand[0]);
    if (imm_form && opfield[11:8] == 4'd0)
      a_r11_no_rotate: assert (operand == XLEN'(opfield[7:0]) && carry_out == carry_in);
  end

  assign carry_we = s_bit && !(alu_op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11});

  always_comb begin
    if (alu_op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11} || !s_bit)
      a_r12_arith_keeps_carry: assert (!carry_we);
  end
endmodule

// File: tb/shifter_operand_tb.sv
module shifter_operand_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imm_form;
  logic [11:0] opfield;
  logic [31:0] rm_val, rs_val, pc;
  logic        carry_in, s_bit;
  logic [3:0]  alu_op;
  logic [31:0] operand;
  logic        carry_out, carry_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  shifter_operand u_dut (
    .imm_form(imm_form), .opfield(opfield), .rm_val(rm_val), .rs_val(rs_val),
    .pc(pc), .carry_in(carry_in), .s_bit(s_bit), .alu_op(alu_op),
    .operand(operand), .carry_out(carry_out), .carry_we(carry_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model(input bit immf, input logic [11:0] f,
                                input logic [31:0] rmv, input logic [31:0] rsv,
                                input logic [31:0] pcv, input bit cin,
                                output logic [31:0] r, output bit c);
    logic [31:0] v;
    int n;
    bit reg_amt;
    v = (f[3:0] == 4'd15) ? pcv + 32'd8 : rmv;
    c = cin;
    if (immf) begin
      v = {24'd0, f[7:0]};
      for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
      r = v;
      c = (f[11:8] != 0) ? v[31] : cin;
      return;
    end
    reg_amt = f[4];
    n = reg_amt ? int'(rsv[7:0]) : int'(f[11:7]);
    if (reg_amt && n == 0) begin r = v; return; end
    case (f[6:5])
      2'd0: for (int i = 0; i < n; i++) begin c = v[31]; v = v << 1; end
      2'd1: begin
        if (n == 0) n = 32;
        for (int i = 0; i < n; i++) begin c = v[0]; v = v >> 1; end
      end
      2'd2: begin
        if (n == 0) n = 32;
        for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
      end
      default: begin
        if (!reg_amt && n == 0) begin c = v[0]; v = {cin, v[31:1]}; end
        else for (int i = 0; i < n; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
      end
    endcase
    r = v;
  endfunction

  function automatic string tag_of(input bit immf, input logic [11:0] f, input logic [31:0] rsv);
    int n;
    if (immf) return "R11";
    if (f[3:0] == 4'd15) return "R1";
    n = f[4] ? int'(rsv[7:0]) : int'(f[11:7]);
    if (f[4] && n == 0) return "R5";
    case (f[6:4])
      3'd0: return (n == 0) ? "R2" : "R3";
      3'd1: return (n < 32) ? "R3" : "R6";
      3'd2, 3'd4: return (n == 0) ? "R4" : "R10";
      3'd3: return (n < 32) ? "R10" : "R6";
      3'd5: return (n < 32) ? "R10" : "R7";
      3'd6: return (n == 0) ? "R8" : "R10";
      default: return (n % 32 == 0) ? "R9" : "R10";
    endcase
  endfunction

  task automatic check_vec(input bit immf, input logic [11:0] f, input logic [31:0] rmv,
                           input logic [31:0] rsv, input bit cin);
    logic [31:0] er;
    bit ec;
    string t;
    @(posedge clk); #1;
    imm_form = immf; opfield = f; rm_val = rmv; rs_val = rsv; carry_in = cin;
    @(negedge clk);
    model(immf, f, rmv, rsv, pc, cin, er, ec);
    t = tag_of(immf, f, rsv);
    checks++;
    if (operand !== er || carry_out !== ec) begin
      fails++;
      $display("FAIL %s field=%h rm=%h rs=%h cin=%0d: got %h/%0d expected %h/%0d",
               t, f, rmv, rsv, cin, operand, carry_out, er, ec);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] srcs [5];
    logic [31:0] er;
    bit ec, ewe;
    srcs[0] = 32'h8000_0001; srcs[1] = 32'hFFFF_FFFF; srcs[2] = 32'h7FFF_FFFE;
    srcs[3] = 32'hA5C3_0F96; srcs[4] = 32'h0000_0000;
    imm_form = 0; opfield = '0; rm_val = '0; rs_val = '0; pc = 32'h0000_1F00;
    carry_in = 0; s_bit = 0; alu_op = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (operand !== 32'd0 || carry_out !== 1'b0 || carry_we !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle: got %h/%0d/%0d expected 0/0/0", operand, carry_out, carry_we);
    end

    for (int ri = 0; ri < 2; ri++)
      for (int kd = 0; kd < 8; kd++)
        for (int si = 0; si < 5; si++)
          for (int cb = 0; cb < 2; cb++) begin
            logic [3:0] idx;
            idx = (ri == 0) ? 4'd3 : 4'd15;
            if (kd[0] == 1'b0) begin
              for (int a = 0; a < 32; a++)
                check_vec(1'b0, {a[4:0], kd[2:0], idx}, srcs[si], 32'h0, cb[0]);
            end else begin
              for (int a = 0; a < 46; a++) begin
                int amt_v;
                amt_v = (a <= 40) ? a : (a == 41 ? 63 : a == 42 ? 64 : a == 43 ? 96 : a == 44 ? 128 : 255);
                check_vec(1'b0, {4'd6, 1'b0, kd[2:0], idx}, srcs[si],
                          {24'hC3E5A7 ^ {srcs[si][23:0]}, amt_v[7:0]}, cb[0]);
              end
            end
          end

    for (int rt = 0; rt < 16; rt++)
      for (int iv = 0; iv < 16; iv++)
        for (int cb = 0; cb < 2; cb++)
          check_vec(1'b1, {rt[3:0], iv[3:0] * 4'd11, iv[3:0] ^ 4'h9}, 32'h1234_5678,
                    32'h0, cb[0]);

    for (int op = 0; op < 16; op++)
      for (int sb = 0; sb < 2; sb++) begin
        @(posedge clk); #1;
        alu_op = op[3:0]; s_bit = sb[0];
        @(negedge clk);
        ewe = sb[0] && !(op inside {2, 3, 4, 5, 6, 7, 10, 11});
        checks++;
        if (carry_we !== ewe) begin
          fails++;
          $display("FAIL R12 op=%0d s=%0d: got %0d expected %0d", op, sb, carry_we, ewe);
        end
      end

    model(1'b0, 12'h00F, 32'h0, 32'h0, pc, 1'b1, er, ec);
    check_vec(1'b0, 12'h00F, 32'hDEAD_BEEF, 32'h0, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule